// File: doc/BRIEF.md
# In-Order Completion Status Tracker

This block collects the outcome of every storage command that a set of downstream transfer engines finishes, and hands those outcomes to software one at a time through a single read-only status word. Each finished command arrives as a one-cycle completion pulse with an error flag. The block queues the outcomes in arrival order and always presents the oldest one.

A read of the status word returns the oldest queued outcome and removes it from the queue, so each command is reported exactly once and in the order it was submitted. Software is expected to perform one status read for every command it issued. It polls until the done bit is set, and it takes the error bit from the same read. The queue is sized for the worst-case number of commands that can be outstanding across all drives at once, so no completion is lost.

Top module: `cpl_status_tracker`

## Requirements
- R1: After reset is released, and after any later reset, the queue is empty and `rd_data_o` is zero. A read issued after a reset returns zero even if completions were queued before that reset.
- R2: A read strobe with `rd_addr_i` equal to 0x04 while at least one completion is queued makes `rd_data_o`, on the next clock, equal the oldest entry. Bit 0 is 1 and bit 1 is that entry's error flag.
- R3: Bits 31:2 of `rd_data_o` are always zero.
- R4: A returning read removes the entry it returned. Once all entries are read, the next read returns zero.
- R5: Entries are returned in the order their completion pulses arrived, each with the error flag that came with it.
- R6: A read at 0x04 while the queue is empty returns zero and removes nothing.
- R7: A read strobe at any address other than 0x04, or a cycle with no read strobe, gives `rd_data_o` equal to zero on the next clock and does not change the queue.
- R8: A completion that arrives in the same cycle as a read into an empty queue is not returned by that read, which gives zero. It is returned by the following read.
- R9: A completion and a returning read in the same cycle are both honoured: the read pops the oldest entry and the new entry joins the tail.
- R10: With default parameters the queue holds 436 entries (2 sources × 218 outstanding) without loss. Reading them back returns every entry in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpl_valid_i | input | 1 | One-cycle pulse per finished command |
| cpl_err_i | input | 1 | Error flag of the finishing command, sampled with `cpl_valid_i` |
| rd_en_i | input | 1 | Register read strobe |
| rd_addr_i | input | ADDR_W (8) | Register read offset |
| rd_data_o | output | 32 | Read data, valid the clock after the strobe |

## Verification
A slipped read or write pointer shows up at the very next status read as a wrong error bit, or as a done bit on a drained queue. Because of that, the sequences mix clean and failing completions in distinct patterns. A count that misses a simultaneous push and pop either loses an entry or reports a stale one, which becomes visible once the queue is drained and the final empty read is not zero. A pop that fires on an empty queue or on a mis-addressed read corrupts the order, and the next in-order read exposes it within one read.

// File: rtl/cst_pkg.sv
package cst_pkg;
  localparam int unsigned STAT_W = 32;

  typedef struct packed {
    logic err;
    logic done;
  } cpl_stat_t;
endpackage

// File: rtl/cst_fifo.sv
module cst_fifo #(
  parameter int unsigned DEPTH = 512,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = PTR_W + 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic push_i,
  input  logic push_err_i,
  input  logic pop_i,
  output logic empty_o,
  output logic full_o,
  output logic head_err_o
);
  logic [DEPTH-1:0] err_mem_q;
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             do_push, do_pop;

  assign empty_o    = (cnt_q == '0);
  assign full_o     = (cnt_q == CNT_W'(DEPTH));
  assign do_pop     = pop_i && !empty_o;
  assign do_push    = push_i && (!full_o || do_pop);
  assign head_err_o = err_mem_q[rd_ptr_q];

  always_ff @(posedge clk_i) begin
    if (do_push) err_mem_q[wr_ptr_q] <= push_err_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (do_push) wr_ptr_q <= (wr_ptr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr_q + 1'b1;
      if (do_pop)  rd_ptr_q <= (rd_ptr_q == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i) |-> !full_o); // R10
  AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o); // R6
  AST_PUSH_POP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && pop_i) |=> $stable(cnt_q)); // R9
endmodule

// File: rtl/cst_rd_port.sv
module cst_rd_port
  import cst_pkg::*;
#(
  parameter int unsigned ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] STAT_OFFSET = ADDR_W'(4)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic              empty_i,
  input  logic              head_err_i,
  output logic              pop_o,
  output logic [STAT_W-1:0] rd_data_o
);
  logic      hit;
  cpl_stat_t stat_d, stat_q;

  assign hit   = rd_en_i && (rd_addr_i == STAT_OFFSET);
  assign pop_o = hit && !empty_i;

  always_comb begin
    stat_d = '0;
    if (pop_o) begin
      stat_d.done = 1'b1;
      stat_d.err  = head_err_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= stat_d;
  end

  assign rd_data_o = {{(STAT_W-2){1'b0}}, stat_q};

  AST_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[STAT_W-1:2] == '0); // R3
  AST_ERR_NEEDS_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[1] |-> rd_data_o[0]); // R2
  AST_MISS_READS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_en_i && rd_addr_i == STAT_OFFSET) |=> rd_data_o == '0); // R7
  AST_EMPTY_READS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && empty_i) |=> rd_data_o == '0); // R6
endmodule

// File: rtl/cpl_status_tracker.sv
module cpl_status_tracker
  import cst_pkg::*;
#(
  parameter int unsigned NUM_SRC     = 2,
  parameter int unsigned MAX_OUT     = 218,
  parameter int unsigned ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] STAT_OFFSET = ADDR_W'(4),
  localparam int unsigned NEED  = NUM_SRC * MAX_OUT,
  localparam int unsigned DEPTH = 1 << $clog2(NEED)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpl_valid_i,
  input  logic              cpl_err_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [STAT_W-1:0] rd_data_o
);
  logic empty, full, head_err, pop;

  cst_fifo #(.DEPTH(DEPTH)) i_fifo (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (cpl_valid_i),
    .push_err_i (cpl_err_i),
    .pop_i      (pop),
    .empty_o    (empty),
    .full_o     (full),
    .head_err_o (head_err)
  );

  cst_rd_port #(.ADDR_W(ADDR_W), .STAT_OFFSET(STAT_OFFSET)) i_rd_port (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_en_i    (rd_en_i),
    .rd_addr_i  (rd_addr_i),
    .empty_i    (empty),
    .head_err_i (head_err),
    .pop_o      (pop),
    .rd_data_o  (rd_data_o)
  );

  AST_NEVER_FULL_PUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpl_valid_i && full) |-> pop); // R10
endmodule

// File: tb/test_cpl_status_tracker.sv
module test_cpl_status_tracker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpl_valid = 1'b0, cpl_err = 1'b0, rd_en = 1'b0;
  logic [7:0]  rd_addr = 8'h00;
  logic [31:0] rd_data;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  cpl_status_tracker i_cpl_status_tracker (
    .clk_i(clk), .rst_ni(rst_n), .cpl_valid_i(cpl_valid), .cpl_err_i(cpl_err),
    .rd_en_i(rd_en), .rd_addr_i(rd_addr), .rd_data_o(rd_data)
  );

  // {valid, err, rd, addr, expected[1:0]}; expected seen one clock later
  localparam int NV = 12;
  localparam logic [12:0] VECS [NV] = '{
    {1'b0, 1'b0, 1'b1, 8'h04, 2'd0}, // R6 empty read
    {1'b1, 1'b0, 1'b0, 8'h00, 2'd0}, // push A clean
    {1'b1, 1'b1, 1'b0, 8'h00, 2'd0}, // push B error
    {1'b1, 1'b0, 1'b1, 8'h08, 2'd0}, // push C, R7 wrong offset
    {1'b0, 1'b0, 1'b1, 8'h04, 2'd1}, // R2 R5 A
    {1'b0, 1'b0, 1'b1, 8'h04, 2'd3}, // R5 B
    {1'b1, 1'b1, 1'b1, 8'h04, 2'd1}, // R9 C out, D in
    {1'b0, 1'b0, 1'b1, 8'h04, 2'd3}, // R9 D
    {1'b0, 1'b0, 1'b1, 8'h04, 2'd0}, // R4 drained
    {1'b1, 1'b0, 1'b1, 8'h04, 2'd0}, // R8 push with read on empty
    {1'b0, 1'b0, 1'b1, 8'h04, 2'd1}, // R8 follow-up read
    {1'b0, 1'b0, 1'b1, 8'h04, 2'd0}  // R4 once only
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic e, input logic r, input logic [7:0] a);
    cpl_valid = v; cpl_err = e; rd_en = r; rd_addr = a;
    @(negedge clk);
    cpl_valid = 1'b0; rd_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", rd_data, 32'h0);

    for (int i = 0; i < NV; i++) begin
      step(VECS[i][12], VECS[i][11], VECS[i][10], VECS[i][9:2]);
      check($sformatf("R2/R5 vec%0d", i), rd_data, {30'h0, VECS[i][1:0]});
      check("R3", {2'b0, rd_data[31:2]}, 32'h0);
    end

    // R1: reset discards queued entries
    step(1'b1, 1'b1, 1'b0, 8'h00);
    step(1'b1, 1'b0, 1'b0, 8'h00);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 in reset", rd_data, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    step(1'b0, 1'b0, 1'b1, 8'h04);
    check("R1 after reset", rd_data, 32'h0);

    // R7: misaddressed reads leave queue intact
    step(1'b1, 1'b1, 1'b0, 8'h00);
    step(1'b0, 1'b0, 1'b1, 8'h00);
    check("R7 addr 0", rd_data, 32'h0);
    step(1'b0, 1'b0, 1'b1, 8'h05);
    check("R7 addr 5", rd_data, 32'h0);
    step(1'b0, 1'b0, 1'b1, 8'h04);
    check("R7 entry kept", rd_data, 32'h3);

    // R10: full worst-case depth
    for (int i = 0; i < 436; i++) step(1'b1, (i % 3) == 0, 1'b0, 8'h00);
    for (int i = 0; i < 436; i++) begin
      step(1'b0, 1'b0, 1'b1, 8'h04);
      check($sformatf("R10 R5 entry%0d", i), rd_data, ((i % 3) == 0) ? 32'h3 : 32'h1);
    end
    step(1'b0, 1'b0, 1'b1, 8'h04);
    check("R10 R4 drained", rd_data, 32'h0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule